// File: doc/BRIEF.md
# Checked Big-Endian Memory Access Unit

This block sits between a processor core and a byte-addressed data RAM. Each cycle the core may present one request: an address, a size code (byte, halfword or word), a read/write flag and 32 bits of write data. Before any byte of storage is touched, the unit compares the address with the configured memory size and checks that it is aligned to the access size. A request that passes both checks is performed. Multi-byte values are laid out big-endian, so the byte at the lowest address carries the most significant bits.

Every request produces a one-cycle completion pulse in the following cycle. The pulse carries either the read data, zero-extended to 32 bits, or a two-bit fault code. Storage is held in four byte-wide synchronous banks, one for each address lane, so a word access completes in a single cycle. The logical memory size is set by `MEM_LOG2` and defaults to 2^23 bytes. The physical backing store is set separately by `STORE_LOG2`, and in-range addresses above it wrap onto it modulo its size.

Top module: `memAccessUnit`

## Requirements
- R1: Size codes are 2'b00 byte, 2'b01 halfword and 2'b10 word. A value of N bytes at address A occupies A..A+N-1, and the most significant byte is stored at A.
- R2: An address that, taken as unsigned, is greater than or equal to 2^MEM_LOG2 completes with fault code 2'b01 and leaves every stored byte unchanged.
- R3: A halfword whose address bit 0 is set, or a word whose address bits 1:0 are not both zero, completes with fault code 2'b10 and leaves every stored byte unchanged.
- R4: When an address is both out of range and misaligned, only the out-of-range code 2'b01 is reported.
- R5: A byte access at any in-range address completes with fault code 2'b00.
- R6: Each request sampled on a clock edge produces a done pulse exactly one cycle later. Requests may be issued back to back, and the done pulse is never high without a request.
- R7: Byte and halfword reads return their value in the low bits of the read data, with all upper bits zero.
- R8: Fault code and read data are zero whenever done is low. Read data is also zero on a write completion and on any faulting completion.
- R9: While reset is asserted and right after it, done is low and the fault code is 2'b00.
- R10: Size code 2'b11 behaves exactly like a word access.
- R11: A read issued in the cycle right after a write to the same location returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | ADDR_W | Byte address |
| reqSize | input | 2 | Access size code |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqWdata | input | 32 | Store data, right-aligned for byte and halfword |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdata | output | 32 | Load data, zero-extended |
| rspFault | output | 2 | 00 none, 01 out of range, 10 misaligned |

## Verification
The range check and the alignment check can both fail on the same request. Their priority decides which code appears. Directed requests provoke this overlap: a misaligned halfword just above the memory size, a word at the all-ones address, and a misaligned word at a high address. Each must report only the range code. The constrained-random mix also produces many such overlaps, and every completion is compared against a bench model that applies the range check first. Because out-of-range addresses wrap onto the physical store, any faulting write that leaked through would corrupt a live byte. Read-backs after each faulting write check that this never happens.

// File: rtl/mau_pkg.sv
package mau_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } accSize_e;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'b00,
    FLT_RANGE    = 2'b01,
    FLT_MISALIGN = 2'b10
  } fault_e;

  localparam int LANES  = 4;
  localparam int DATA_W = 32;

  // Request-cycle strobes from control to datapath.
  typedef struct packed {
    logic [LANES-1:0] laneWe;
    accSize_e         size;
    logic [1:0]       lane;
  } ctrlStrobe_t;

  // Response-cycle strobes from control to datapath.
  typedef struct packed {
    logic     rdValid;
    accSize_e size;
    logic [1:0] lane;
  } respStrobe_t;

endpackage

// File: rtl/mauByteBank.sv
module mauByteBank #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ROW_W-1:0] row,
  input  logic [7:0]       wrByte,
  output logic [7:0]       rdByte
);
  localparam int DEPTH = 1 << ROW_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[row] <= wrByte;
    rdByte <= cells[row];
  end
endmodule

// File: rtl/mauCtrl.sv
module mauCtrl
  import mau_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MEM_LOG2 = 23
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  output ctrlStrobe_t       strb,
  output respStrobe_t       resp,
  output logic              rspDone,
  output logic [1:0]        rspFault
);
  localparam int AW1 = ADDR_W + 1;
  localparam logic [AW1-1:0] MEM_BYTES = AW1'(1) << MEM_LOG2;

  accSize_e         effSize;
  logic [1:0]       lane;
  logic             outOfRange;
  logic             misAlign;
  fault_e           faultNow;
  logic             accOk;
  logic [LANES-1:0] laneMask;

  always_comb begin
    unique case (reqSize)
      2'b00:   effSize = SZ_BYTE;
      2'b01:   effSize = SZ_HALF;
      default: effSize = SZ_WORD;
    endcase
  end

  assign lane       = reqAddr[1:0];
  assign outOfRange = {1'b0, reqAddr} >= MEM_BYTES;

  always_comb begin
    unique case (effSize)
      SZ_HALF: misAlign = lane[0];
      SZ_WORD: misAlign = |lane;
      default: misAlign = 1'b0;
    endcase
  end

  // Range is judged first; alignment only matters for an in-range address.
  always_comb begin
    if (outOfRange)    faultNow = FLT_RANGE;
    else if (misAlign) faultNow = FLT_MISALIGN;
    else               faultNow = FLT_NONE;
  end

  assign accOk = reqValid && (faultNow == FLT_NONE);

  always_comb begin
    unique case (effSize)
      SZ_BYTE: laneMask = 4'b0001 << lane;
      SZ_HALF: laneMask = 4'b0011 << lane;
      default: laneMask = 4'b1111;
    endcase
  end

  always_comb begin
    strb.laneWe = (accOk && reqWrite) ? laneMask : '0;
    strb.size   = effSize;
    strb.lane   = lane;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspDone      <= 1'b0;
      rspFault     <= FLT_NONE;
      resp.rdValid <= 1'b0;
      resp.size    <= SZ_BYTE;
      resp.lane    <= 2'b00;
    end else begin
      rspDone      <= reqValid;
      rspFault     <= reqValid ? faultNow : FLT_NONE;
      resp.rdValid <= accOk && !reqWrite;
      resp.size    <= effSize;
      resp.lane    <= lane;
    end
  end

  // R6: a request always completes on the following edge
  p_done_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspDone);
  // R6: no completion without a request
  p_done_has_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> $past(reqValid));
  // R8: fault code quiet between completions
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rspDone |-> rspFault == FLT_NONE);
  // R5: byte accesses never misaligned
  p_byte_aligned_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqSize == 2'b00 |=> rspFault != FLT_MISALIGN);
  // R4: range wins over alignment
  p_range_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && ({1'b0, reqAddr} >= MEM_BYTES) |=> rspFault == FLT_RANGE);
endmodule

// File: rtl/mauDatapath.sv
module mauDatapath
  import mau_pkg::*;
#(
  parameter int ROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  respStrobe_t       resp,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspRdata
);
  logic [7:0] wrLane [LANES];
  logic [7:0] rdLane [LANES];

  // Steer store bytes: bank b holds the byte at address offset b.
  for (genvar b = 0; b < LANES; b++) begin : g_bank
    always_comb begin
      unique case (strb.size)
        SZ_BYTE: wrLane[b] = reqWdata[7:0];
        SZ_HALF: wrLane[b] = (strb.lane == 2'(b)) ? reqWdata[15:8] : reqWdata[7:0];
        default: wrLane[b] = reqWdata[DATA_W-1-8*b -: 8];
      endcase
    end

    mauByteBank #(.ROW_W(ROW_W)) i_bank (
      .clk    (clk),
      .we     (strb.laneWe[b]),
      .row    (row),
      .wrByte (wrLane[b]),
      .rdByte (rdLane[b])
    );
  end

  logic [1:0] laneNext;
  assign laneNext = resp.lane + 2'd1;

  always_comb begin
    if (!resp.rdValid) begin
      rspRdata = '0;
    end else begin
      unique case (resp.size)
        SZ_BYTE: rspRdata = {24'd0, rdLane[resp.lane]};
        SZ_HALF: rspRdata = {16'd0, rdLane[resp.lane], rdLane[laneNext]};
        default: rspRdata = {rdLane[0], rdLane[1], rdLane[2], rdLane[3]};
      endcase
    end
  end

  // R1: a store enables exactly one, two or four lanes
  p_lane_count_r1: assert property (@(posedge clk) disable iff (!rstN)
    |strb.laneWe |-> ($countones(strb.laneWe) == 1 || $countones(strb.laneWe) == 2 ||
                      $countones(strb.laneWe) == 4));
  // R3: halfword stores only touch an aligned lane pair
  p_half_pair_r3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strb.laneWe) == 2 |-> (strb.laneWe == 4'b0011 || strb.laneWe == 4'b1100));
endmodule

// File: rtl/memAccessUnit.sv
module memAccessUnit
  import mau_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MEM_LOG2   = 23,
  parameter int STORE_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [31:0]       reqWdata,
  output logic              rspDone,
  output logic [31:0]       rspRdata,
  output logic [1:0]        rspFault
);
  localparam int ROW_W = STORE_LOG2 - 2;

  ctrlStrobe_t      strb;
  respStrobe_t      resp;
  logic [ROW_W-1:0] row;

  assign row = reqAddr[STORE_LOG2-1:2];

  mauCtrl #(.ADDR_W(ADDR_W), .MEM_LOG2(MEM_LOG2)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .reqWrite (reqWrite),
    .strb     (strb),
    .resp     (resp),
    .rspDone  (rspDone),
    .rspFault (rspFault)
  );

  mauDatapath #(.ROW_W(ROW_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .resp     (resp),
    .row      (row),
    .reqWdata (reqWdata),
    .rspRdata (rspRdata)
  );

  // R2: a cycle that writes storage never completes with a fault
  p_write_clean_r2: assert property (@(posedge clk) disable iff (!rstN)
    |strb.laneWe |=> rspFault == FLT_NONE);
  // R8: faulting completions return zero data
  p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspFault != FLT_NONE |-> rspRdata == '0);
endmodule

// File: tb/test_memAccessUnit.sv
module test_memAccessUnit;
  localparam int MEM_LOG2   = 23;
  localparam int STORE_LOG2 = 10;
  localparam int STORE      = 1 << STORE_LOG2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic        rspDone;
  logic [31:0] rspRdata;
  logic [1:0]  rspFault;

  int total = 0;
  int bad   = 0;
  logic [7:0] bm [STORE];

  always #2 clk = ~clk;

  memAccessUnit #(.ADDR_W(32), .MEM_LOG2(MEM_LOG2), .STORE_LOG2(STORE_LOG2)) i_memAccessUnit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .rspDone(rspDone), .rspRdata(rspRdata),
    .rspFault(rspFault)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] expFault(input logic [31:0] a, input logic [1:0] sz);
    if (a >= (32'd1 << MEM_LOG2)) return 2'b01;
    if (sz == 2'b01 && a[0]) return 2'b10;
    if (sz[1] && a[1:0] != 2'b00) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [31:0] expRead(input logic [31:0] a, input logic [1:0] sz);
    int i;
    i = int'(a % STORE);
    if (sz == 2'b00) return {24'd0, bm[i]};
    if (sz == 2'b01) return {16'd0, bm[i], bm[i+1]};
    return {bm[i], bm[i+1], bm[i+2], bm[i+3]};
  endfunction

  // One request, completed and checked against the model; the next call is back to back.
  task automatic access(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd, input string req);
    logic [1:0]  ef;
    logic [31:0] er;
    int i;
    ef = expFault(a, sz);
    er = (wr || ef != 2'b00) ? 32'd0 : expRead(a, sz);
    reqValid = 1'b1; reqAddr = a; reqSize = sz; reqWrite = wr; reqWdata = wd;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (wr && ef == 2'b00) begin
      i = int'(a % STORE);
      if (sz == 2'b00) bm[i] = wd[7:0];
      else if (sz == 2'b01) begin bm[i] = wd[15:8]; bm[i+1] = wd[7:0]; end
      else begin bm[i] = wd[31:24]; bm[i+1] = wd[23:16]; bm[i+2] = wd[15:8]; bm[i+3] = wd[7:0]; end
    end
    check(rspDone == 1'b1, {req, " R6 done"}, 32'(rspDone), 32'd1);
    check(rspFault == ef, {req, " fault"}, 32'(rspFault), 32'(ef));
    check(rspRdata == er, {req, " rdata"}, rspRdata, er);
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state, R8 idle outputs
    check(rspDone == 1'b0, "R9 done in reset", 32'(rspDone), 0);
    check(rspFault == 2'b00, "R9 fault in reset", 32'(rspFault), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rspDone == 1'b0 && rspFault == 2'b00, "R9 after reset", 32'({rspDone, rspFault}), 0);
    check(rspRdata == 32'd0, "R8 idle rdata", rspRdata, 0);

    for (int r = 0; r < STORE / 4; r++) access(1'b1, 2'b10, 32'(r * 4), $urandom, "fill");

    // R1 big-endian layout
    access(1'b1, 2'b10, 32'h10, 32'h11223344, "R1 word store");
    access(1'b0, 2'b00, 32'h10, 0, "R1 byte0 is msb");
    access(1'b0, 2'b00, 32'h13, 0, "R1 byte3 is lsb");
    access(1'b0, 2'b01, 32'h12, 0, "R7 half zero-ext");
    access(1'b1, 2'b00, 32'h11, 32'hFFFFFFAB, "R1 byte store");
    access(1'b0, 2'b10, 32'h10, 0, "R11 read after write");
    check(expRead(32'h10, 2'b10) == 32'h11AB3344, "R1 model", expRead(32'h10, 2'b10), 32'h11AB3344);
    access(1'b1, 2'b01, 32'h16, 32'h0000CAFE, "R1 half store");
    access(1'b0, 2'b00, 32'h17, 0, "R7 byte zero-ext");

    // R2 out of range, aliasing onto row 0
    access(1'b1, 2'b10, 32'h0080_0000, 32'hDEADBEEF, "R2 range store");
    access(1'b0, 2'b10, 32'h0, 0, "R2 store unchanged");
    access(1'b1, 2'b00, 32'hFFFF_FC03, 32'h5A, "R2 top byte store");
    access(1'b0, 2'b10, 32'h0, 0, "R2 unchanged again");
    access(1'b0, 2'b10, 32'h007F_FFFC, 0, "R2 last word in range");

    // R3 misaligned
    access(1'b1, 2'b10, 32'h21, 32'h01020304, "R3 word mis store");
    access(1'b1, 2'b01, 32'h23, 32'h0000BEEF, "R3 half mis store");
    access(1'b0, 2'b10, 32'h20, 0, "R3 store unchanged");
    access(1'b0, 2'b10, 32'h26, 0, "R3 word mis load");

    // R4 both faults at once
    access(1'b0, 2'b01, 32'h0080_0001, 0, "R4 half both");
    access(1'b1, 2'b10, 32'hFFFF_FFFF, 32'h1, "R4 word both");
    access(1'b0, 2'b10, 32'h0123_4562, 0, "R4 word both 2");

    // R5 odd byte
    access(1'b0, 2'b00, 32'h3, 0, "R5 odd byte");
    access(1'b1, 2'b00, 32'h7F_FFFF, 32'h77, "R5 last byte");

    // R10 size code 3
    access(1'b1, 2'b11, 32'h40, 32'hA1B2C3D4, "R10 size3 store");
    access(1'b0, 2'b10, 32'h40, 0, "R10 readback");
    access(1'b0, 2'b11, 32'h42, 0, "R10 size3 misaligned");

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a;
      logic [1:0]  sz;
      sz = 2'($urandom_range(0, 2));
      if ($urandom_range(0, 7) == 0) a = 32'h0080_0000 | $urandom;
      else a = 32'($urandom_range(0, STORE - 4));
      access(1'($urandom_range(0, 1)), sz, a, $urandom, "R1 random");
    end

    @(negedge clk);
    check(rspDone == 1'b0, "R6 no done when idle", 32'(rspDone), 0);
    check(rspFault == 2'b00 && rspRdata == 32'd0, "R8 idle quiet", rspRdata, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule